// File: doc/BRIEF.md
# Weighted Random Instruction Stream Source

This block is a hardware stimulus source for a small processor under test. After a start pulse it hands out a stream of 32-bit instruction words, one per accepted transfer, drawn from a tiny test instruction set of three arithmetic operations (add, sub, mac) plus an all-zero no-operation word. A 16-bit linear feedback shift register supplies the randomness. Software-visible knobs are plain input pins: three per-opcode occurrence weights, a mode that pins the output to one opcode, and a mode that plants one chosen register in the operand fields so that neighbouring instructions read what the one before wrote.

A per-opcode latency pin set makes the block pad the stream with no-operation words after an instruction whose result takes time, so that the next real instruction does not arrive early. A programmable count sets how many real instructions a run contains. Padding words do not count towards it. When the last real instruction has been taken, the block raises its done flag and holds it until the next start.

The word leaves through a valid/ready port. Valid stays high and the word stays frozen until ready is seen high at a clock edge. A transfer takes place on each edge where both are high. The block never withdraws a word it has offered. The configuration pins are sampled live and must be held steady for the length of a run.

Top module: `instr_stream_gen`

## Requirements
- R1: While reset is applied and after its release, before any start, out_valid is 0, done is 0 and out_word is 0.
- R2: Word layout: bits 31:24 hold the opcode byte (add 0x01, sub 0x02, mac 0x03). For add and sub, bits 23:16 are {0000, dst}, 15:8 are {0000, src1} and 7:0 are {0000, src2}. For mac, bits 23:16 are {src3, dst}, 15:8 are {0000, src1} and 7:0 are {0000, src2}. The no-operation word is 0x00000000.
- R3: The random state is a 16-bit Galois shift register. Its next value is (s >> 1) XOR (s[0] ? 0xB400 : 0). Start loads it from seed, and a seed of 0 loads 0x0001. It advances once per accepted real instruction and at no other time. The operand fields come from the current state: dst = s[3:0], src1 = s[7:4], src2 = s[11:8], src3 = s[15:12].
- R4: With r = s[15:8], a weight total T = w_add + w_sub + w_mac and k = (r * T) >> 8, the opcode is add if k < w_add, sub if k < w_add + w_sub, and mac otherwise. A total of 0 selects add.
- R5: When sel_en is 1, every real instruction carries the opcode whose low two bits equal sel_op (sel_op 0 selects add), whatever the weights.
- R6: When ovr_en is 1, dst is ovr_reg in every real instruction, and src1 is ovr_reg in every real instruction of a run except the first.
- R7: After a real instruction whose opcode latency L (lat_add, lat_sub or lat_mac) is nonzero, exactly L no-operation words are transferred before the next real instruction. No padding follows the last instruction of a run.
- R8: A run transfers exactly `count` real instructions. No-operation padding is not counted. A count of 0 offers no word at all and goes straight to done.
- R9: While out_valid is 1 and out_ready is 0, out_valid and out_word keep their values on the next cycle.
- R10: done rises in the cycle after the last counted instruction is accepted. out_valid is 0 while done is 1, and done stays 1 until a start. A start pulse during a run is ignored, and so is a change to seed during a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (honoured only when idle or done) |
| seed | input | 16 | Random state loaded at start |
| count | input | 16 | Number of real instructions in the run |
| w_add | input | 8 | Occurrence weight of add |
| w_sub | input | 8 | Occurrence weight of sub |
| w_mac | input | 8 | Occurrence weight of mac |
| lat_add | input | 4 | Padding words after add |
| lat_sub | input | 4 | Padding words after sub |
| lat_mac | input | 4 | Padding words after mac |
| sel_en | input | 1 | Restrict output to one opcode |
| sel_op | input | 2 | Opcode chosen when sel_en is 1 |
| ovr_en | input | 1 | Enable forced register operand |
| ovr_reg | input | 4 | Register index planted in dst and src1 |
| out_valid | output | 1 | Word offered |
| out_ready | input | 1 | Consumer accepts the word |
| out_word | output | 32 | Instruction word |
| done | output | 1 | Run finished |

## Verification
Two events can fall on the same clock edge. The first is the acceptance of the final counted instruction. The second is the arrival of a nonzero latency for that same instruction. The design must then raise done and must not pad. The bench sweeps every selectable opcode against latencies 0 to 3 at short counts, so that the last word is often a long-latency one, and judges it by the absence of any further valid word and by done arriving exactly one cycle later. Back-pressure stalls are interleaved with padding, and a start pulse with a changed seed is injected mid-run, so that the hold rule and the ignored start are checked against the same arithmetic model of the stream.

// File: rtl/isg_pkg.sv
package isg_pkg;
  typedef enum logic [7:0] {
    OP_NOP = 8'h00,
    OP_ADD = 8'h01,
    OP_SUB = 8'h02,
    OP_MAC = 8'h03
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INSN,
    ST_PAD,
    ST_DONE
  } gen_st_e;

  localparam int RND_W = 16;
  localparam logic [RND_W-1:0] RND_TAPS = 16'hB400;
endpackage

// File: rtl/isg_lfsr.sv
module isg_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] nxt;
  assign nxt = (q >> 1) ^ (q[0] ? TAPS : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= ONE;
    end else if (load) begin
      q <= (seed == '0) ? ONE : seed;
    end else if (step) begin
      q <= nxt;
    end
  end

  assert_lfsr_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0);

  assert_lfsr_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(q));
endmodule

// File: rtl/isg_op_pick.sv
module isg_op_pick
  import isg_pkg::*;
#(
  parameter int WGT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rnd,
  input  logic [WGT_W-1:0] w_add,
  input  logic [WGT_W-1:0] w_sub,
  input  logic [WGT_W-1:0] w_mac,
  input  logic             sel_en,
  input  logic [1:0]       sel_op,
  output op_e              op
);
  localparam int SUM_W  = WGT_W + 2;
  localparam int PROD_W = SUM_W + 8;

  logic [SUM_W-1:0]  total;
  logic [SUM_W-1:0]  edge_add;
  logic [SUM_W-1:0]  edge_sub;
  logic [PROD_W-1:0] prod;
  logic [SUM_W-1:0]  scaled;
  op_e               drawn;

  assign edge_add = {2'b00, w_add};
  assign edge_sub = edge_add + {2'b00, w_sub};
  assign total    = edge_sub + {2'b00, w_mac};
  assign prod     = {{SUM_W{1'b0}}, rnd} * {8'b0, total};
  assign scaled   = prod[PROD_W-1:8];

  always_comb begin
    if (total == '0)            drawn = OP_ADD;
    else if (scaled < edge_add) drawn = OP_ADD;
    else if (scaled < edge_sub) drawn = OP_SUB;
    else                        drawn = OP_MAC;
  end

  always_comb begin
    if (sel_en) begin
      case (sel_op)
        2'd2:    op = OP_SUB;
        2'd3:    op = OP_MAC;
        default: op = OP_ADD;
      endcase
    end else begin
      op = drawn;
    end
  end

  assert_pick_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en && sel_op != 2'd0) |-> (op[1:0] == sel_op));

  assert_pick_zero_weight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_en && w_add == '0 && w_mac == '0 && w_sub != '0) |-> (op == OP_SUB));
endmodule

// File: rtl/isg_word_build.sv
module isg_word_build
  import isg_pkg::*;
(
  input  op_e              op,
  input  logic [RND_W-1:0] rnd,
  input  logic             ovr_en,
  input  logic [3:0]       ovr_reg,
  input  logic             first,
  output logic [31:0]      word
);
  logic [3:0] dst;
  logic [3:0] src1;
  logic [3:0] src2;
  logic [3:0] src3;

  always_comb begin
    dst  = rnd[3:0];
    src1 = rnd[7:4];
    src2 = rnd[11:8];
    src3 = rnd[15:12];
    if (ovr_en) begin
      dst = ovr_reg;
      if (!first) src1 = ovr_reg;
    end
  end

  always_comb begin
    if (op == OP_MAC) begin
      word = {op, src3, dst, 4'b0000, src1, 4'b0000, src2};
    end else begin
      word = {op, 4'b0000, dst, 4'b0000, src1, 4'b0000, src2};
    end
  end
endmodule

// File: rtl/instr_stream_gen.sv
module instr_stream_gen
  import isg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WGT_W = 8,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      seed,
  input  logic [CNT_W-1:0] count,
  input  logic [WGT_W-1:0] w_add,
  input  logic [WGT_W-1:0] w_sub,
  input  logic [WGT_W-1:0] w_mac,
  input  logic [LAT_W-1:0] lat_add,
  input  logic [LAT_W-1:0] lat_sub,
  input  logic [LAT_W-1:0] lat_mac,
  input  logic             sel_en,
  input  logic [1:0]       sel_op,
  input  logic             ovr_en,
  input  logic [3:0]       ovr_reg,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_word,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [LAT_W-1:0] LAT_ONE = {{(LAT_W-1){1'b0}}, 1'b1};

  gen_st_e          state;
  logic [CNT_W-1:0] remaining;
  logic [LAT_W-1:0] pad_left;
  logic             first;
  logic [RND_W-1:0] rnd;
  op_e              op_cur;
  logic [31:0]      insn_word;
  logic [LAT_W-1:0] lat_cur;
  logic             accept;
  logic             launch;

  assign launch = start && (state == ST_IDLE || state == ST_DONE);
  assign accept = out_valid && out_ready;

  isg_lfsr #(.W(RND_W), .TAPS(RND_TAPS)) i_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (launch),
    .seed  (seed),
    .step  (accept && state == ST_INSN),
    .q     (rnd)
  );

  isg_op_pick #(.WGT_W(WGT_W)) i_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .rnd    (rnd[15:8]),
    .w_add  (w_add),
    .w_sub  (w_sub),
    .w_mac  (w_mac),
    .sel_en (sel_en),
    .sel_op (sel_op),
    .op     (op_cur)
  );

  isg_word_build i_build (
    .op      (op_cur),
    .rnd     (rnd),
    .ovr_en  (ovr_en),
    .ovr_reg (ovr_reg),
    .first   (first),
    .word    (insn_word)
  );

  always_comb begin
    case (op_cur)
      OP_SUB:  lat_cur = lat_sub;
      OP_MAC:  lat_cur = lat_mac;
      default: lat_cur = lat_add;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      remaining <= '0;
      pad_left  <= '0;
      first     <= 1'b1;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            first     <= 1'b1;
            remaining <= count;
            pad_left  <= '0;
            state     <= (count == '0) ? ST_DONE : ST_INSN;
          end
        end
        ST_INSN: begin
          if (accept) begin
            remaining <= remaining - CNT_ONE;
            first     <= 1'b0;
            if (remaining == CNT_ONE) begin
              state <= ST_DONE;
            end else if (lat_cur != '0) begin
              pad_left <= lat_cur;
              state    <= ST_PAD;
            end
          end
        end
        ST_PAD: begin
          if (accept) begin
            pad_left <= pad_left - LAT_ONE;
            if (pad_left == LAT_ONE) state <= ST_INSN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = (state == ST_INSN) || (state == ST_PAD);
  assign done      = (state == ST_DONE);
  assign out_word  = (state == ST_INSN) ? insn_word : 32'h0;

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  assert_pad_follows_slow_insn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && state == ST_INSN && lat_cur != '0 && remaining != CNT_ONE)
      |=> (out_valid && out_word == 32'h0));

  assert_last_raises_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && state == ST_INSN && remaining == CNT_ONE) |=> done);

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_no_valid_when_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && done));

  assert_real_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INSN) |-> (out_word[31:24] != 8'h00 && out_word[31:26] == 6'd0));
endmodule

// File: tb/test_instr_stream_gen.sv
module test_instr_stream_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] seed = 16'h0;
  logic [15:0] count = 16'h0;
  logic [7:0]  w_add = 8'd1, w_sub = 8'd1, w_mac = 8'd1;
  logic [3:0]  lat_add = 4'd0, lat_sub = 4'd0, lat_mac = 4'd0;
  logic        sel_en = 1'b0;
  logic [1:0]  sel_op = 2'd0;
  logic        ovr_en = 1'b0;
  logic [3:0]  ovr_reg = 4'd0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_word;
  logic        done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_stream_gen i_instr_stream_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .count(count),
    .w_add(w_add), .w_sub(w_sub), .w_mac(w_mac),
    .lat_add(lat_add), .lat_sub(lat_sub), .lat_mac(lat_mac),
    .sel_en(sel_en), .sel_op(sel_op), .ovr_en(ovr_en), .ovr_reg(ovr_reg),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R3 model of the random state
  function automatic logic [15:0] rnd_next(input logic [15:0] s);
    return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0);
  endfunction

  // R4/R5 model of opcode choice
  function automatic logic [7:0] model_op(input logic [15:0] s);
    int tot, k;
    if (sel_en) return (sel_op == 2'd0) ? 8'h01 : {6'd0, sel_op};
    tot = int'(w_add) + int'(w_sub) + int'(w_mac);
    if (tot == 0) return 8'h01;
    k = (int'(s[15:8]) * tot) >> 8;
    if (k < int'(w_add)) return 8'h01;
    if (k < int'(w_add) + int'(w_sub)) return 8'h02;
    return 8'h03;
  endfunction

  // R2/R6 model of the word
  function automatic logic [31:0] model_word(input logic [15:0] s, input bit first_i);
    logic [7:0] op;
    logic [3:0] d, a, b, c;
    op = model_op(s);
    d = s[3:0]; a = s[7:4]; b = s[11:8]; c = s[15:12];
    if (ovr_en) begin
      d = ovr_reg;
      if (!first_i) a = ovr_reg;
    end
    if (op == 8'h03) return {op, c, d, 4'h0, a, 4'h0, b};
    return {op, 4'h0, d, 4'h0, a, 4'h0, b};
  endfunction

  function automatic int model_lat(input logic [7:0] op);
    if (op == 8'h02) return int'(lat_sub);
    if (op == 8'h03) return int'(lat_mac);
    return int'(lat_add);
  endfunction

  task automatic run_case(input int n, input bit bp, input bit mid_start);
    logic [15:0] s;
    int rem, pend, reals, k;
    bit first_m, stalled;
    logic [31:0] held, exp_w;
    logic [7:0] op;
    s = (seed == 16'h0) ? 16'h0001 : seed;
    rem = n; pend = 0; reals = 0; first_m = 1; stalled = 0; held = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 0;
    while (1) begin
      if (rem == 0) begin
        check(done === 1'b1, "R10 done after last", {31'd0, done}, 32'd1);
        check(out_valid === 1'b0, "R10 no valid when done", {31'd0, out_valid}, 32'd0);
        check(reals == n, "R8 instruction count", reals, n);
        break;
      end
      if (mid_start && k == 3) begin
        start = 1'b1; seed = seed ^ 16'h5A5A;
      end else if (mid_start && k == 4) begin
        start = 1'b0; seed = seed ^ 16'h5A5A;
      end
      out_ready = bp ? ((k % 3) != 2) : 1'b1;
      check(out_valid === 1'b1, "R8 valid during run", {31'd0, out_valid}, 32'd1);
      if (stalled) check(out_word === held, "R9 word held under stall", out_word, held);
      exp_w = (pend > 0) ? 32'h0 : model_word(s, first_m);
      if (out_valid && out_ready) begin
        check(out_word === exp_w, (pend > 0) ? "R7 padding word" : "R2 R3 R4 R6 instruction word", out_word, exp_w);
        if (pend > 0) begin
          pend--;
        end else begin
          op = model_op(s);
          s = rnd_next(s);
          rem--; reals++; first_m = 0;
          pend = (rem == 0) ? 0 : model_lat(op);
        end
        stalled = 0;
      end else begin
        stalled = 1; held = out_word;
      end
      k++;
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 reset valid", {31'd0, out_valid}, 32'd0);
    check(done === 1'b0, "R1 reset done", {31'd0, done}, 32'd0);
    check(out_word === 32'h0, "R1 reset word", out_word, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && done === 1'b0, "R1 idle after reset", {30'd0, out_valid, done}, 32'd0);

    // Equal weights with back-pressure, seed 0 maps to 1 (R3)
    seed = 16'h0; count = 16'd40;
    run_case(40, 1, 0);
    // Done stays high with no start (R10)
    repeat (5) @(negedge clk);
    check(done === 1'b1, "R10 done sticky", {31'd0, done}, 32'd1);

    // Weight sweep with mac weight 2 (R4)
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        w_add = 8'(a); w_sub = 8'(b); w_mac = 8'd2;
        seed = 16'(16'h1357 + a * 97 + b * 13); count = 16'd6;
        run_case(6, (a + b) % 2 == 1, 0);
      end
    end
    // Only sub weighted (R4), all-zero weights give add (R4)
    w_add = 0; w_sub = 8'd7; w_mac = 0; seed = 16'hACE1; count = 16'd10;
    run_case(10, 0, 0);
    w_sub = 0; count = 16'd5;
    run_case(5, 1, 0);

    // Selection mode vs latency sweep (R5, R7)
    w_add = 8'd5; w_sub = 8'd5; w_mac = 8'd5; sel_en = 1'b1;
    for (int o = 0; o < 4; o++) begin
      for (int l = 0; l < 4; l++) begin
        sel_op = 2'(o); lat_add = 4'(l); lat_sub = 4'(l); lat_mac = 4'(l);
        seed = 16'(16'h0F0F + o * 31 + l); count = 16'(3 + l);
        run_case(3 + l, l % 2 == 0, 0);
      end
    end
    sel_en = 1'b0;

    // Override with mixed latencies (R6, R7)
    ovr_en = 1'b1; ovr_reg = 4'd5; w_add = 8'd3; w_sub = 8'd2; w_mac = 8'd1;
    lat_add = 0; lat_sub = 4'd1; lat_mac = 4'd2; seed = 16'hBEEF; count = 16'd20;
    run_case(20, 1, 0);
    ovr_en = 1'b0;

    // Zero count (R8)
    count = 16'd0;
    run_case(0, 0, 0);

    // Start and seed change during a run are ignored (R10)
    seed = 16'h2468; count = 16'd12; lat_mac = 4'd1;
    run_case(12, 1, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule